// File: doc/BRIEF.md
# Fractional Complex Multiplier with Output Scaler

This block multiplies two complex numbers held in fractional two's complement. Each operand has a 16-bit real part and a 16-bit imaginary part, and a new operand pair can enter on every clock. The block returns a 32-bit real part and a 32-bit imaginary part together, three clocks after the operands arrive. The real part is the real-by-real product minus the imaginary-by-imaginary product. The imaginary part is the sum of the two cross products. Each partial product is kept in the Q1.31 format, which is the raw product shifted left by one place.

One fractional product cannot be represented: minus one times minus one. That product is replaced by the largest positive value, and a trap flag reports it. After the add/subtract stage there is an output scaler, set for each operand pair by a 2-bit weight. When that pair is tagged for rounding, the result is also rounded to its upper 16 bits. Sums, shifts and rounding that leave the signed range saturate and raise an overflow flag.

Top module: `cplx_frac_mul`

## Requirements
- R1: With weight 00, the scaler in normal mode and rounding off, out_re equals sat32(2·ar·br − 2·ai·bi) and out_im equals sat32(2·ar·bi + 2·ai·br). All products are signed.
- R2: One operand pair is accepted on every clock. out_valid and the matching result appear exactly three rising edges after the edge that samples in_valid high. Idle cycles give out_valid low.
- R3: A partial product whose operands are both 16'h8000 is replaced by 32'h7FFF_FFFF. out_trap is high with the result that contains it.
- R4: When the sum or difference leaves the 32-bit signed range, it saturates to 32'h7FFF_FFFF or 32'h8000_0000 and out_ovf is high.
- R5: When fixed_scale is low, weight code 2'b11 shifts both parts left by one place. A part that would overflow saturates to the extreme of its sign and raises out_ovf.
- R6: When fixed_scale is low, weight code 2'b01 shifts both parts right by one place with sign extension.
- R7: When fixed_scale is low, weight codes 2'b00 and 2'b10 leave the result unshifted.
- R8: When fixed_scale is high, the weight input is ignored and no shift is applied.
- R9: With round_en high, each part becomes ((v + 32'h0000_8000) with bits 15:0 cleared). A positive result above 32'h7FFF_0000 saturates to 32'h7FFF_0000 and raises out_ovf. Rounding is applied after the scaler.
- R10: During reset, out_valid, out_re, out_im, out_ovf and out_trap are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_re | input | 16 | Operand A real part, Q1.15 |
| a_im | input | 16 | Operand A imaginary part, Q1.15 |
| b_re | input | 16 | Operand B real part, Q1.15 |
| b_im | input | 16 | Operand B imaginary part, Q1.15 |
| weight | input | 2 | Scaler code for this pair (normal mode) |
| fixed_scale | input | 1 | High: scaler bypassed, weight ignored |
| round_en | input | 1 | Round this pair's result to its upper 16 bits |
| out_valid | output | 1 | Result present |
| out_re | output | 32 | Result real part |
| out_im | output | 32 | Result imaginary part |
| out_ovf | output | 1 | Saturation occurred in add/subtract, shift or rounding |
| out_trap | output | 1 | A minus-one-squared partial product was replaced |

## Verification
The bench builds the block with its default width of 16 bits. At this width the operand extremes 16'h8000 and 16'h7FFF can be reached by drawing them often in the random stimulus. That lets random traffic hit the trap, saturation in the add/subtract stage, and overflow in the left shift and in rounding, as well as plain mid-range products. The weight code, the fixed_scale bit, the rounding bit and in_valid bubbles are varied on every cycle. This shows that the per-pair controls stay aligned with their data through all three stages.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    // Scaler codes driven by the weight input in normal mode
    typedef enum logic [1:0] {
        WT_NONE  = 2'b00,
        WT_RIGHT = 2'b01,
        WT_HOLD  = 2'b10,
        WT_LEFT  = 2'b11
    } weight_e;
endpackage

// File: rtl/cfm_mult_stage.sv
module cfm_mult_stage #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic [1:0]           weight,
    input  logic                 fixed_scale,
    input  logic                 round_en,
    output logic                 valid_o,
    output logic [3:0][PW-1:0]   prod_o,
    output logic                 trap_o,
    output logic [1:0]           wt_o,
    output logic                 rnd_o
);
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0]        MAXP = {1'b0, {(PW-1){1'b1}}};

    typedef struct packed {
        logic               valid;
        logic [3:0][PW-1:0] prod;
        logic               trap;
        logic [1:0]         wt;
        logic               rnd;
    } s1_t;

    s1_t s1_d, s1_q;

    // product order: 0 re*re, 1 im*im, 2 re(a)*im(b), 3 im(a)*re(b)
    logic signed [DW-1:0] op_x [4];
    logic signed [DW-1:0] op_y [4];
    logic [3:0][PW-1:0]   prod_v;
    logic [3:0]           trap_v;

    assign op_x[0] = a_re;  assign op_y[0] = b_re;
    assign op_x[1] = a_im;  assign op_y[1] = b_im;
    assign op_x[2] = a_re;  assign op_y[2] = b_im;
    assign op_x[3] = a_im;  assign op_y[3] = b_re;

    for (genvar g = 0; g < 4; g++) begin : g_mul
        logic signed [PW-1:0] full;
        assign full      = op_x[g] * op_y[g];
        assign trap_v[g] = (op_x[g] == MINV) && (op_y[g] == MINV);
        assign prod_v[g] = trap_v[g] ? MAXP : {full[PW-2:0], 1'b0};
    end

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.prod  = prod_v;
        s1_d.trap  = |trap_v;
        s1_d.wt    = fixed_scale ? 2'b00 : weight;
        s1_d.rnd   = round_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign valid_o = s1_q.valid;
    assign prod_o  = s1_q.prod;
    assign trap_o  = s1_q.trap;
    assign wt_o    = s1_q.wt;
    assign rnd_o   = s1_q.rnd;

    // R3: minus one squared on the real pair yields the largest positive value
    assert_trap_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_re == MINV && b_re == MINV) |=> (prod_o[0] == MAXP && trap_o));
endmodule

// File: rtl/cfm_addsub_stage.sv
module cfm_addsub_stage #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [3:0][PW-1:0] prod_i,
    input  logic               trap_i,
    input  logic [1:0]         wt_i,
    input  logic               rnd_i,
    output logic               valid_o,
    output logic [PW-1:0]      re_o,
    output logic [PW-1:0]      im_o,
    output logic               ovf_o,
    output logic               trap_o,
    output logic [1:0]         wt_o,
    output logic               rnd_o
);
    localparam logic [PW-1:0] MAXP = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] MINP = {1'b1, {(PW-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] re;
        logic [PW-1:0] im;
        logic          ovf;
        logic          trap;
        logic [1:0]    wt;
        logic          rnd;
    } s2_t;

    s2_t s2_d, s2_q;
    logic [PW:0] re_w, im_w;
    logic        re_of, im_of;

    always_comb begin
        re_w  = {prod_i[0][PW-1], prod_i[0]} - {prod_i[1][PW-1], prod_i[1]};
        im_w  = {prod_i[2][PW-1], prod_i[2]} + {prod_i[3][PW-1], prod_i[3]};
        re_of = re_w[PW] != re_w[PW-1];
        im_of = im_w[PW] != im_w[PW-1];
        s2_d.valid = valid_i;
        s2_d.re    = re_of ? (re_w[PW] ? MINP : MAXP) : re_w[PW-1:0];
        s2_d.im    = im_of ? (im_w[PW] ? MINP : MAXP) : im_w[PW-1:0];
        s2_d.ovf   = re_of | im_of;
        s2_d.trap  = trap_i;
        s2_d.wt    = wt_i;
        s2_d.rnd   = rnd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign valid_o = s2_q.valid;
    assign re_o    = s2_q.re;
    assign im_o    = s2_q.im;
    assign ovf_o   = s2_q.ovf;
    assign trap_o  = s2_q.trap;
    assign wt_o    = s2_q.wt;
    assign rnd_o   = s2_q.rnd;

    // R4: an overflow flag always comes with at least one saturated part
    assert_sat_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (re_o == MAXP || re_o == MINP || im_o == MAXP || im_o == MINP));
endmodule

// File: rtl/cfm_scale_round.sv
module cfm_scale_round
    import cfm_pkg::*;
#(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [PW-1:0] re_i,
    input  logic [PW-1:0] im_i,
    input  logic          ovf_i,
    input  logic          trap_i,
    input  logic [1:0]    wt_i,
    input  logic          rnd_i,
    output logic          valid_o,
    output logic [PW-1:0] re_o,
    output logic [PW-1:0] im_o,
    output logic          ovf_o,
    output logic          trap_o
);
    localparam logic [PW-1:0] MAXP = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] MINP = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] RMAX = {1'b0, {(PW-DW-1){1'b1}}, {DW{1'b0}}};
    localparam logic [PW:0]   HALF = {{(PW+1-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] re;
        logic [PW-1:0] im;
        logic          ovf;
        logic          trap;
    } s3_t;

    s3_t s3_d, s3_q;

    function automatic logic [PW:0] scale(input logic [PW-1:0] v, input logic [1:0] wt);
        // returns {overflow, value}
        logic [PW:0] r;
        unique case (weight_e'(wt))
            WT_LEFT: begin
                if (v[PW-1] != v[PW-2]) r = {1'b1, (v[PW-1] ? MINP : MAXP)};
                else                    r = {1'b0, v[PW-2:0], 1'b0};
            end
            WT_RIGHT: r = {1'b0, v[PW-1], v[PW-1:1]};
            default:  r = {1'b0, v};
        endcase
        return r;
    endfunction

    function automatic logic [PW:0] rounder(input logic [PW-1:0] v, input logic en);
        logic [PW:0] s;
        logic [PW:0] r;
        s = {v[PW-1], v} + HALF;
        if (!en)                r = {1'b0, v};
        else if (s[PW] != s[PW-1]) r = {1'b1, RMAX};
        else                    r = {1'b0, s[PW-1:DW], {DW{1'b0}}};
        return r;
    endfunction

    logic [PW:0] re_s, im_s, re_r, im_r;

    always_comb begin
        re_s = scale(re_i, wt_i);
        im_s = scale(im_i, wt_i);
        re_r = rounder(re_s[PW-1:0], rnd_i);
        im_r = rounder(im_s[PW-1:0], rnd_i);
        s3_d.valid = valid_i;
        s3_d.re    = re_r[PW-1:0];
        s3_d.im    = im_r[PW-1:0];
        s3_d.ovf   = ovf_i | re_s[PW] | im_s[PW] | re_r[PW] | im_r[PW];
        s3_d.trap  = trap_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign valid_o = s3_q.valid;
    assign re_o    = s3_q.re;
    assign im_o    = s3_q.im;
    assign ovf_o   = s3_q.ovf;
    assign trap_o  = s3_q.trap;

    // R5, R9: an overflow raised in this stage leaves a part at an extreme
    assert_scale_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_i && (wt_i == 2'b11 || rnd_i)) |=>
        (!ovf_o || re_o == MAXP || re_o == MINP || re_o == RMAX ||
                   im_o == MAXP || im_o == MINP || im_o == RMAX));
    // R6: right shift never overflows and keeps the sign
    assert_right_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_i == 2'b01 && !rnd_i && !ovf_i) |=> (!ovf_o && re_o[PW-1] == $past(re_i[PW-1])));
endmodule

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul #(
    parameter int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] a_re,
    input  logic [DW-1:0] a_im,
    input  logic [DW-1:0] b_re,
    input  logic [DW-1:0] b_im,
    input  logic [1:0]    weight,
    input  logic          fixed_scale,
    input  logic          round_en,
    output logic          out_valid,
    output logic [PW-1:0] out_re,
    output logic [PW-1:0] out_im,
    output logic          out_ovf,
    output logic          out_trap
);
    logic               v1, t1, r1;
    logic [3:0][PW-1:0] p1;
    logic [1:0]         w1;
    logic               v2, o2, t2, r2;
    logic [PW-1:0]      re2, im2;
    logic [1:0]         w2;

    cfm_mult_stage #(.DW(DW)) u_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .weight(weight), .fixed_scale(fixed_scale), .round_en(round_en),
        .valid_o(v1), .prod_o(p1), .trap_o(t1), .wt_o(w1), .rnd_o(r1)
    );

    cfm_addsub_stage #(.DW(DW)) u_addsub (
        .clk(clk), .rst_n(rst_n), .valid_i(v1), .prod_i(p1), .trap_i(t1),
        .wt_i(w1), .rnd_i(r1), .valid_o(v2), .re_o(re2), .im_o(im2),
        .ovf_o(o2), .trap_o(t2), .wt_o(w2), .rnd_o(r2)
    );

    cfm_scale_round #(.DW(DW)) u_scale (
        .clk(clk), .rst_n(rst_n), .valid_i(v2), .re_i(re2), .im_i(im2),
        .ovf_i(o2), .trap_i(t2), .wt_i(w2), .rnd_i(r2),
        .valid_o(out_valid), .re_o(out_re), .im_o(out_im),
        .ovf_o(out_ovf), .trap_o(out_trap)
    );

    // R2: every accepted pair emerges exactly three edges later
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    // R9: rounded results carry clear low halves
    assert_round_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && round_en) |-> ##3 (out_re[DW-1:0] == '0 && out_im[DW-1:0] == '0));
endmodule

// File: tb/cplx_frac_mul_bench.sv
`timescale 1ns/1ps
module cplx_frac_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic [1:0]  weight = '0;
    logic        fixed_scale = 1'b0, round_en = 1'b0;
    logic        out_valid, out_ovf, out_trap;
    logic [31:0] out_re, out_im;

    int n_chk = 0, n_bad = 0;

    bit          pv  [1:3];
    logic [31:0] pre [1:3];
    logic [31:0] pim [1:3];
    bit          povf[1:3];
    bit          ptrp[1:3];
    string       ptag[1:3];

    always #2.5 clk = ~clk;

    cplx_frac_mul u_cplx_frac_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .weight(weight), .fixed_scale(fixed_scale), .round_en(round_en),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .out_ovf(out_ovf), .out_trap(out_trap)
    );

    localparam longint PMAX = 64'sd2147483647;
    localparam longint PMIN = -64'sd2147483648;

    function automatic longint fprod(input logic [15:0] x, input logic [15:0] y, inout bit tr);
        longint p = 2 * longint'($signed(x)) * longint'($signed(y));
        if (p > PMAX) begin p = PMAX; tr = 1; end
        return p;
    endfunction

    function automatic longint clamp(input longint v, inout bit of);
        if (v > PMAX) begin of = 1; return PMAX; end
        if (v < PMIN) begin of = 1; return PMIN; end
        return v;
    endfunction

    function automatic longint post(input longint v, input logic [1:0] w, input bit fs,
                                    input bit rn, inout bit of);
        longint r = v;
        longint q;
        if (!fs && w == 2'b11) r = clamp(v * 2, of);
        else if (!fs && w == 2'b01) r = v >>> 1;
        if (rn) begin
            q = (r + 32768) >>> 16;
            if (q > 32767) begin of = 1; q = 32767; end
            r = q * 65536;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input bit v, input logic [15:0] ar, input logic [15:0] ai,
                         input logic [15:0] br, input logic [15:0] bi, input logic [1:0] w,
                         input bit fs, input bit rn, input string tag);
        bit tr = 0, of = 0;
        longint rr, ii, ri, ir, re, im;
        in_valid = v; a_re = ar; a_im = ai; b_re = br; b_im = bi;
        weight = w; fixed_scale = fs; round_en = rn;
        rr = fprod(ar, br, tr); ii = fprod(ai, bi, tr);
        ri = fprod(ar, bi, tr); ir = fprod(ai, br, tr);
        re = post(clamp(rr - ii, of), w, fs, rn, of);
        im = post(clamp(ri + ir, of), w, fs, rn, of);
        @(posedge clk);
        for (int k = 3; k > 1; k--) begin
            pv[k] = pv[k-1]; pre[k] = pre[k-1]; pim[k] = pim[k-1];
            povf[k] = povf[k-1]; ptrp[k] = ptrp[k-1]; ptag[k] = ptag[k-1];
        end
        pv[1] = v; pre[1] = re[31:0]; pim[1] = im[31:0];
        povf[1] = of; ptrp[1] = tr; ptag[1] = tag;
        @(negedge clk);
        check(out_valid == pv[3], "R2", "valid", {31'd0, out_valid}, {31'd0, pv[3]});
        if (pv[3]) begin
            check(out_re == pre[3] && out_im == pim[3], ptag[3], "re", out_re, pre[3]);
            if (out_im != pim[3]) $display("     (%s im actual=%h expected=%h)", ptag[3], out_im, pim[3]);
            check(out_ovf == povf[3], ptag[3], "ovf", {31'd0, out_ovf}, {31'd0, povf[3]});
            check(out_trap == ptrp[3], ptag[3], "trap", {31'd0, out_trap}, {31'd0, ptrp[3]});
        end
    endtask

    function automatic logic [15:0] pick();
        int s = $urandom % 8;
        if (s == 0) return 16'h8000;
        if (s == 1) return 16'h7FFF;
        return 16'($urandom);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 1; k <= 3; k++) begin
            pv[k] = 0; pre[k] = '0; pim[k] = '0; povf[k] = 0; ptrp[k] = 0; ptag[k] = "R2";
        end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(!out_valid && out_re == '0 && out_im == '0 && !out_ovf && !out_trap,
              "R10", "reset", out_re, 32'h0);
        rst_n = 1'b1;
        // directed corners
        apply(1, 16'h4000, 16'h2000, 16'h4000, 16'hE000, 2'b00, 0, 0, "R1");
        apply(1, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 2'b00, 0, 0, "R3");
        apply(1, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 2'b00, 0, 0, "R3");
        apply(1, 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 2'b00, 0, 0, "R4");
        apply(1, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 2'b00, 0, 0, "R4");
        apply(1, 16'h6000, 16'h0000, 16'h6000, 16'h0000, 2'b11, 0, 0, "R5");
        apply(1, 16'h2000, 16'h0000, 16'hA000, 16'h1000, 2'b11, 0, 0, "R5");
        apply(1, 16'hC000, 16'h3000, 16'h4000, 16'h0001, 2'b01, 0, 0, "R6");
        apply(1, 16'h1234, 16'h8765, 16'h4321, 16'h5678, 2'b10, 0, 0, "R7");
        apply(1, 16'h6000, 16'h0000, 16'h6000, 16'h0000, 2'b11, 1, 0, "R8");
        apply(1, 16'h4000, 16'h1234, 16'h3000, 16'h0101, 2'b01, 1, 0, "R8");
        apply(1, 16'h8000, 16'h0000, 16'h8000, 16'h0000, 2'b00, 0, 1, "R9");
        apply(1, 16'h1234, 16'hC321, 16'h0FED, 16'h7001, 2'b00, 0, 1, "R9");
        apply(0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 2'b11, 0, 1, "R2");
        // random traffic over all controls (R1, R2, R4..R9)
        for (int i = 0; i < 3000; i++) begin
            bit v = ($urandom % 5) != 0;
            apply(v, pick(), pick(), pick(), pick(), 2'($urandom), 1'($urandom % 4 == 0),
                  1'($urandom % 3 == 0), "R1");
        end
        for (int i = 0; i < 3; i++) apply(0, '0, '0, '0, '0, 2'b00, 0, 0, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule